// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block keeps time of day and calendar date as BCD bytes. It places them in the eight highest byte locations of a byte-addressed space and backs the low part of that space with a small RAM. A once-per-second strobe advances the time. Host software reads and writes every location over a plain address/data bus. A second, narrower access path reaches the same locations through an address latch that is loaded one byte at a time.

Register map, from the top address downward: year, month, date, weekday with century flag, hours, minutes, seconds with stop flag, control. Below these, at 16 bytes under the top, sits a read-only flags byte. The RAM holds `RAM_BYTES` bytes from address zero. Two 16-byte RAM windows can each be hidden and write-protected by a lock bit, and each lock bit flips on a one-cycle strobe.

Top module: `rtc_nvram_bank`

## Requirements
- R1: After reset, the clock reads 00:00:00 with weekday 1, date 01, month 01, year 00, century 0, stop 0 and control 0x00, and both locks are open. A read strobe returns its data on the cycle after the strobe.
- R2: Each tick with stop clear advances seconds in BCD. Seconds 59 carries to minutes, minutes 59 carries to hours, and hours 23 carries to the date. On that date carry the weekday goes to the next value, with 7 followed by 1.
- R3: The date rolls to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other months, and in month 02 after 29 if the two-digit year is a multiple of 4 (00 included) and after 28 otherwise. Month 12 rolls to 01 and increments the year. Year 99 rolls to 00 and inverts the century flag.
- R4: Bit 7 of the seconds location is a stop flag. Every seconds write stores it, including a write whose seconds field is rejected. While it is set, ticks change nothing. A read returns it in bit 7 above the BCD seconds.
- R5: A time write is dropped when any BCD digit exceeds 9 or the value is out of range. The fields and limits are: seconds and minutes, bits 6:0, 0–59; hours, bits 5:0, 0–23; date, bits 5:0, 1–31; month, bits 4:0, 1–12; year, all 8 bits, 0–99; weekday, bits 2:0, 1–7.
- R6: A write to the weekday location always stores bit 6 as the century flag. It stores bits 2:0 only if they are valid. A read returns the century in bit 6, the weekday in bits 2:0 and zero elsewhere.
- R7: A write to the control location stores the data with bits 7 and 4 forced to 1 and bit 5 forced to 0. The flags location reads 0x00 and ignores writes. The seven locations between the flags and control locations read 0xFF.
- R8: Lock bit 0 (toggled by `lock_tgl[0]`) covers 0x20–0x2F and lock bit 1 (toggled by `lock_tgl[1]`) covers 0x30–0x3F. A locked window ignores writes and reads 0xFF. Its contents show again once it is unlocked.
- R9: Addresses from `RAM_BYTES` up to the flags location read 0xFF and ignore writes. They do not alias onto RAM.
- R10: On the indexed path, `port_sel` 0 loads the low address byte and 1 loads the high address bits. A write with `port_sel` 3 stores the data at the latched address and clears the latch to 0. A read with `port_sel` 3 returns the data at the latched address one cycle later. Reads with `port_sel` 0, 1 or 2 return 0xFF.
- R11: When a write to any location from control to year lands in the same cycle as a tick, that tick is discarded and the written value is what reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle strobe per elapsed second |
| bus_addr | input | ADDR_W | Byte address for direct access |
| bus_wdata | input | 8 | Direct write data |
| bus_we | input | 1 | Direct write strobe |
| bus_re | input | 1 | Direct read strobe |
| bus_rdata | output | 8 | Direct read data, valid the cycle after `bus_re` |
| lock_tgl | input | 2 | Per-window lock toggle strobes |
| port_sel | input | 2 | Indexed path register select |
| port_wdata | input | 8 | Indexed path write data |
| port_we | input | 1 | Indexed path write strobe |
| port_re | input | 1 | Indexed path read strobe |
| port_rdata | output | 8 | Indexed path read data, valid the cycle after `port_re` |

## Verification
The assertions assume that a direct write and an indexed data write never fall in the same cycle, that the tick is a single-cycle pulse, and that reset is applied before the first strobe. The bench drives every strobe for exactly one cycle between falling edges. It never overlaps the two access paths, and the only stimulus it pairs with a tick is a time write, which it does on purpose. Each calendar corner is reached by loading a time one second before the boundary and then applying a single tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef struct packed {
      logic       stop;
      logic [6:0] sec;
      logic [6:0] min;
      logic [5:0] hr;
      logic       cent;
      logic [2:0] wday;
      logic [5:0] date;
      logic [4:0] mon;
      logic [7:0] year;
   } rtc_time_t;

   // Both digits decimal and the value inside [lo, hi].
   function automatic logic bcd_ok(input logic [7:0] v, input int lo, input int hi);
      int b;
      b = int'(v[7:4]) * 10 + int'(v[3:0]);
      return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9) && (b >= lo) && (b <= hi);
   endfunction

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // Last date of a month in BCD; 10t+u is a multiple of 4 exactly when 2t+u is.
   function automatic logic [7:0] last_day(input logic [4:0] mon, input logic [7:0] yr);
      logic [4:0] s;
      s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
      case (mon)
         5'h02:                      return (s[1:0] == 2'b00) ? 8'h29 : 8'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
   import rtc_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            wr_en,
   input  logic [2:0]      wr_idx,
   input  logic [7:0]      wr_data,
   output logic [7:0][7:0] reg_view
);

   rtc_time_t  t_q, t_tick;
   logic [7:0] ctrl_q;
   logic [7:0] sec_i, min_i, hr_i, date_i, mon_i, yr_i, ld;

   always_comb begin
      sec_i  = bcd_inc({1'b0, t_q.sec});
      min_i  = bcd_inc({1'b0, t_q.min});
      hr_i   = bcd_inc({2'b0, t_q.hr});
      date_i = bcd_inc({2'b0, t_q.date});
      mon_i  = bcd_inc({3'b0, t_q.mon});
      yr_i   = bcd_inc(t_q.year);
      ld     = last_day(t_q.mon, t_q.year);
      t_tick = t_q;
      if (t_q.sec != 7'h59) t_tick.sec = sec_i[6:0];
      else begin
         t_tick.sec = '0;
         if (t_q.min != 7'h59) t_tick.min = min_i[6:0];
         else begin
            t_tick.min = '0;
            if (t_q.hr != 6'h23) t_tick.hr = hr_i[5:0];
            else begin
               t_tick.hr   = '0;
               t_tick.wday = (t_q.wday == 3'd7) ? 3'd1 : t_q.wday + 3'd1;
               if ({2'b0, t_q.date} != ld) t_tick.date = date_i[5:0];
               else begin
                  t_tick.date = 6'h01;
                  if (t_q.mon != 5'h12) t_tick.mon = mon_i[4:0];
                  else begin
                     t_tick.mon = 5'h01;
                     if (t_q.year != 8'h99) t_tick.year = yr_i;
                     else begin
                        t_tick.year = 8'h00;
                        t_tick.cent = ~t_q.cent;
                     end
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         t_q    <= '{stop: 1'b0, sec: '0, min: '0, hr: '0, cent: 1'b0,
                     wday: 3'd1, date: 6'h01, mon: 5'h01, year: 8'h00};
         ctrl_q <= 8'h00;
      end else if (wr_en) begin
         case (wr_idx)
            3'd0: ctrl_q <= (wr_data & ~8'hA0) | 8'h90;
            3'd1: begin
               t_q.stop <= wr_data[7];
               if (bcd_ok({1'b0, wr_data[6:0]}, 0, 59)) t_q.sec <= wr_data[6:0];
            end
            3'd2: if (bcd_ok({1'b0, wr_data[6:0]}, 0, 59)) t_q.min  <= wr_data[6:0];
            3'd3: if (bcd_ok({2'b0, wr_data[5:0]}, 0, 23)) t_q.hr   <= wr_data[5:0];
            3'd4: begin
               t_q.cent <= wr_data[6];
               if (bcd_ok({5'b0, wr_data[2:0]}, 1, 7)) t_q.wday <= wr_data[2:0];
            end
            3'd5: if (bcd_ok({2'b0, wr_data[5:0]}, 1, 31)) t_q.date <= wr_data[5:0];
            3'd6: if (bcd_ok({3'b0, wr_data[4:0]}, 1, 12)) t_q.mon  <= wr_data[4:0];
            default: if (bcd_ok(wr_data, 0, 99))           t_q.year <= wr_data;
         endcase
      end else if (tick && !t_q.stop) begin
         t_q <= t_tick;
      end
   end

   assign reg_view[0] = ctrl_q;
   assign reg_view[1] = {t_q.stop, t_q.sec};
   assign reg_view[2] = {1'b0, t_q.min};
   assign reg_view[3] = {2'b0, t_q.hr};
   assign reg_view[4] = {1'b0, t_q.cent, 3'b0, t_q.wday};
   assign reg_view[5] = {2'b0, t_q.date};
   assign reg_view[6] = {3'b0, t_q.mon};
   assign reg_view[7] = t_q.year;

   AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !t_q.stop && !wr_en) |=> (t_q.sec != $past(t_q.sec))); // R2
   AST_WDAY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      t_q.wday != 3'd0); // R2
   AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (t_q.stop && tick && !wr_en) |=> $stable(t_q)); // R4
   AST_BAD_SEC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == 3'd1 && !bcd_ok({1'b0, wr_data[6:0]}, 0, 59)) |=> $stable(t_q.sec)); // R5
   AST_CTRL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == 3'd0) |=> (ctrl_q[7] && ctrl_q[4] && !ctrl_q[5])); // R7
   AST_WRITE_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && tick && wr_idx == 3'd2 && bcd_ok({1'b0, wr_data[6:0]}, 0, 59))
      |=> (t_q.min == $past(wr_data[6:0]) && $stable(t_q.sec))); // R11

endmodule

// File: rtl/rtc_ram_window.sv
module rtc_ram_window #(
   parameter int AW        = 13,
   parameter int DEPTH     = 256,
   parameter int LOCK_BASE = 32,
   parameter int LOCK_SPAN = 16,
   parameter int N_LOCKS   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [AW-1:0]      waddr,
   input  logic [7:0]         wdata,
   input  logic [N_LOCKS-1:0] lock_tgl,
   input  logic [AW-1:0]      raddr_a,
   input  logic [AW-1:0]      raddr_b,
   output logic [7:0]         rdata_a,
   output logic [7:0]         rdata_b
);

   localparam int            IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW-1:0] DEPTH_A = AW'(DEPTH);

   logic [7:0]         mem [DEPTH];
   logic [N_LOCKS-1:0] lock_q, win_w, win_a, win_b;
   logic               ok_w, ok_a, ok_b;

   for (genvar g = 0; g < N_LOCKS; g++) begin : g_win
      localparam logic [AW-1:0] LO = AW'(LOCK_BASE + g * LOCK_SPAN);
      localparam logic [AW-1:0] HI = AW'(LOCK_BASE + (g + 1) * LOCK_SPAN);
      assign win_w[g] = (waddr   >= LO) && (waddr   < HI);
      assign win_a[g] = (raddr_a >= LO) && (raddr_a < HI);
      assign win_b[g] = (raddr_b >= LO) && (raddr_b < HI);
   end

   assign ok_w = (waddr   < DEPTH_A) && ((win_w & lock_q) == '0);
   assign ok_a = (raddr_a < DEPTH_A) && ((win_a & lock_q) == '0);
   assign ok_b = (raddr_b < DEPTH_A) && ((win_b & lock_q) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) lock_q <= '0;
      else        lock_q <= lock_q ^ lock_tgl;
   end

   always_ff @(posedge clk) begin
      if (we && ok_w) mem[waddr[IW-1:0]] <= wdata;
   end

   assign rdata_a = ok_a ? mem[raddr_a[IW-1:0]] : 8'hFF;
   assign rdata_b = ok_b ? mem[raddr_b[IW-1:0]] : 8'hFF;

   AST_LOCK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_tgl[0] && !lock_q[0] && raddr_a == AW'(LOCK_BASE)) |=> (rdata_a == 8'hFF)); // R8

endmodule

// File: rtl/rtc_index_port.sv
module rtc_index_port #(
   parameter int AW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    sel,
   input  logic [7:0]    wdata,
   input  logic          we,
   output logic [AW-1:0] idx_addr,
   output logic          fwd_we
);

   localparam int HB = AW - 8;

   always_ff @(posedge clk) begin
      if (!rst_n) idx_addr <= '0;
      else if (we) begin
         case (sel)
            2'd0:    idx_addr[7:0]    <= wdata;
            2'd1:    idx_addr[AW-1:8] <= wdata[HB-1:0];
            2'd3:    idx_addr         <= '0;
            default: ;
         endcase
      end
   end

   assign fwd_we = we && (sel == 2'd3);

   AST_IDX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == 2'd3) |=> (idx_addr == '0)); // R10

endmodule

// File: rtl/rtc_nvram_bank.sv
module rtc_nvram_bank #(
   parameter int ADDR_W    = 13,
   parameter int RAM_BYTES = 256,
   parameter int LOCK_BASE = 32,
   parameter int LOCK_SPAN = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [7:0]        bus_rdata,
   input  logic [1:0]        lock_tgl,
   input  logic [1:0]        port_sel,
   input  logic [7:0]        port_wdata,
   input  logic              port_we,
   input  logic              port_re,
   output logic [7:0]        port_rdata
);

   localparam int            TOP_I     = (1 << ADDR_W) - 1;
   localparam logic [ADDR_W-1:0] CLK_BASE  = ADDR_W'(TOP_I - 7);
   localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(TOP_I - 15);
   localparam logic [ADDR_W-1:0] RAM_TOP   = ADDR_W'(RAM_BYTES);

   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_aw
      $error("ADDR_W must lie in 9..16");
   end
   if (RAM_BYTES < 2 || RAM_BYTES > TOP_I - 15) begin : g_bad_ram
      $error("RAM_BYTES must stay below the flags location");
   end
   if (LOCK_BASE + 2 * LOCK_SPAN > RAM_BYTES) begin : g_bad_lock
      $error("lock windows must lie inside the RAM");
   end

   logic [ADDR_W-1:0] idx_addr, wr_addr;
   logic              fwd_we, wr_any;
   logic [7:0]        wr_data, ram_a, ram_b;
   logic [7:0][7:0]   reg_view;

   // Direct bus takes the write slot when both paths write together.
   assign wr_any  = bus_we | fwd_we;
   assign wr_addr = bus_we ? bus_addr  : idx_addr;
   assign wr_data = bus_we ? bus_wdata : port_wdata;

   rtc_index_port #(.AW(ADDR_W)) i_idx (
      .clk(clk), .rst_n(rst_n), .sel(port_sel), .wdata(port_wdata),
      .we(port_we), .idx_addr(idx_addr), .fwd_we(fwd_we)
   );

   rtc_time_core i_core (
      .clk(clk), .rst_n(rst_n), .tick(tick_1hz),
      .wr_en(wr_any && (wr_addr >= CLK_BASE)), .wr_idx(wr_addr[2:0]),
      .wr_data(wr_data), .reg_view(reg_view)
   );

   rtc_ram_window #(.AW(ADDR_W), .DEPTH(RAM_BYTES), .LOCK_BASE(LOCK_BASE),
                    .LOCK_SPAN(LOCK_SPAN), .N_LOCKS(2)) i_ram (
      .clk(clk), .rst_n(rst_n), .we(wr_any), .waddr(wr_addr), .wdata(wr_data),
      .lock_tgl(lock_tgl), .raddr_a(bus_addr), .raddr_b(idx_addr),
      .rdata_a(ram_a), .rdata_b(ram_b)
   );

   function automatic logic [7:0] map_read(input logic [ADDR_W-1:0] a,
                                           input logic [7:0] ram_d,
                                           input logic [7:0][7:0] view);
      if (a >= CLK_BASE)  return view[a[2:0]];
      if (a == FLAG_ADDR) return 8'h00;
      if (a > FLAG_ADDR)  return 8'hFF;
      return ram_d;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata  <= 8'h00;
         port_rdata <= 8'h00;
      end else begin
         if (bus_re)  bus_rdata  <= map_read(bus_addr, ram_a, reg_view);
         if (port_re) port_rdata <= (port_sel == 2'd3) ? map_read(idx_addr, ram_b, reg_view) : 8'hFF;
      end
   end

   AST_HOLE_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr >= RAM_TOP && bus_addr < FLAG_ADDR) |=> (bus_rdata == 8'hFF)); // R9
   AST_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr == FLAG_ADDR) |=> (bus_rdata == 8'h00)); // R7

endmodule

// File: tb/test_rtc_nvram_bank.sv
module test_rtc_nvram_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_1hz = 1'b0;
   logic [12:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_we = 1'b0, bus_re = 1'b0;
   logic [7:0]  bus_rdata;
   logic [1:0]  lock_tgl = '0;
   logic [1:0]  port_sel = '0;
   logic [7:0]  port_wdata = '0;
   logic        port_we = 1'b0, port_re = 1'b0;
   logic [7:0]  port_rdata;

   int n_vec = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   rtc_nvram_bank i_rtc_nvram_bank (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .lock_tgl(lock_tgl), .port_sel(port_sel), .port_wdata(port_wdata),
      .port_we(port_we), .port_re(port_re), .port_rdata(port_rdata)
   );

   localparam logic [12:0] A_CTRL = 13'h1FF8, A_SEC = 13'h1FF9, A_MIN = 13'h1FFA,
                           A_HR = 13'h1FFB, A_WD = 13'h1FFC, A_DATE = 13'h1FFD,
                           A_MON = 13'h1FFE, A_YR = 13'h1FFF;

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic bwrite(input logic [12:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk); bus_we = 1'b0;
   endtask

   task automatic bwrite_tick(input logic [12:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1; tick_1hz = 1'b1;
      @(negedge clk); bus_we = 1'b0; tick_1hz = 1'b0;
   endtask

   task automatic bcheck(input string tag, input logic [12:0] a, input logic [7:0] exp);
      @(negedge clk); bus_addr = a; bus_re = 1'b1;
      @(negedge clk); bus_re = 1'b0;
      check(tag, bus_rdata, exp);
   endtask

   task automatic tick();
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
   endtask

   task automatic toggle(input logic [1:0] m);
      @(negedge clk); lock_tgl = m;
      @(negedge clk); lock_tgl = '0;
   endtask

   task automatic pwrite(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk); port_sel = s; port_wdata = d; port_we = 1'b1;
      @(negedge clk); port_we = 1'b0;
   endtask

   task automatic pcheck(input string tag, input logic [1:0] s, input logic [7:0] exp);
      @(negedge clk); port_sel = s; port_re = 1'b1;
      @(negedge clk); port_re = 1'b0;
      check(tag, port_rdata, exp);
   endtask

   task automatic set_time(input logic [7:0] s, m, h, wd, dt, mo, y);
      bwrite(A_SEC, s); bwrite(A_MIN, m); bwrite(A_HR, h); bwrite(A_WD, wd);
      bwrite(A_DATE, dt); bwrite(A_MON, mo); bwrite(A_YR, y);
   endtask

   task automatic t_reset();
      bcheck("R1 ctrl", A_CTRL, 8'h00); bcheck("R1 sec", A_SEC, 8'h00);
      bcheck("R1 min", A_MIN, 8'h00);   bcheck("R1 hr", A_HR, 8'h00);
      bcheck("R1 wday", A_WD, 8'h01);   bcheck("R1 date", A_DATE, 8'h01);
      bcheck("R1 mon", A_MON, 8'h01);   bcheck("R1 year", A_YR, 8'h00);
   endtask

   task automatic t_advance();
      tick(); tick(); tick();
      bcheck("R2 three ticks", A_SEC, 8'h03);
      for (int i = 0; i < 7; i++) tick();
      bcheck("R2 bcd digit carry", A_SEC, 8'h10);
      set_time(8'h59, 8'h00, 8'h00, 8'h02, 8'h10, 8'h03, 8'h20);
      tick();
      bcheck("R2 sec wrap", A_SEC, 8'h00); bcheck("R2 min carry", A_MIN, 8'h01);
      set_time(8'h59, 8'h59, 8'h00, 8'h02, 8'h10, 8'h03, 8'h20);
      tick();
      bcheck("R2 hour carry", A_HR, 8'h01); bcheck("R2 min wrap", A_MIN, 8'h00);
      set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h03, 8'h20);
      tick();
      bcheck("R2 hr wrap", A_HR, 8'h00); bcheck("R2 weekday 7 to 1", A_WD, 8'h01);
      bcheck("R2 date carry", A_DATE, 8'h16);
   endtask

   task automatic t_calendar();
      set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23);
      tick();
      bcheck("R3 30-day month date", A_DATE, 8'h01); bcheck("R3 30-day month", A_MON, 8'h05);
      set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
      tick();
      bcheck("R3 common feb", A_DATE, 8'h01); bcheck("R3 common feb mon", A_MON, 8'h03);
      set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
      tick();
      bcheck("R3 leap feb 29", A_DATE, 8'h29);
      set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
      tick();
      bcheck("R3 leap feb end", A_DATE, 8'h01); bcheck("R3 leap feb end mon", A_MON, 8'h03);
      set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
      tick();
      bcheck("R3 year 00 leap", A_DATE, 8'h29);
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h31, 8'h12, 8'h99);
      tick();
      bcheck("R3 year wrap", A_YR, 8'h00); bcheck("R3 month wrap", A_MON, 8'h01);
      bcheck("R3 date wrap", A_DATE, 8'h01); bcheck("R3 century flips", A_WD, 8'h44);
      set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h07, 8'h10);
      tick();
      bcheck("R3 31-day month", A_MON, 8'h08);
   endtask

   task automatic t_stop();
      set_time(8'h92, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
      bcheck("R4 stop readback", A_SEC, 8'h92);
      tick(); tick();
      bcheck("R4 stopped", A_SEC, 8'h92);
      bwrite(A_SEC, 8'hE0);
      bcheck("R4 stop kept, bad sec dropped", A_SEC, 8'h92);
      bwrite(A_SEC, 8'h12); tick();
      bcheck("R4 running again", A_SEC, 8'h13);
   endtask

   task automatic t_range();
      set_time(8'h00, 8'h10, 8'h05, 8'h01, 8'h15, 8'h06, 8'h42);
      bwrite(A_MIN, 8'h60);  bcheck("R5 min 60", A_MIN, 8'h10);
      bwrite(A_MIN, 8'h5A);  bcheck("R5 min bad digit", A_MIN, 8'h10);
      bwrite(A_SEC, 8'h4F);  bcheck("R5 sec bad digit", A_SEC, 8'h00);
      bwrite(A_HR, 8'h24);   bcheck("R5 hr 24", A_HR, 8'h05);
      bwrite(A_HR, 8'h23);   bcheck("R5 hr 23", A_HR, 8'h23);
      bwrite(A_MON, 8'h13);  bcheck("R5 mon 13", A_MON, 8'h06);
      bwrite(A_MON, 8'h00);  bcheck("R5 mon 0", A_MON, 8'h06);
      bwrite(A_DATE, 8'h32); bcheck("R5 date 32", A_DATE, 8'h15);
      bwrite(A_DATE, 8'h00); bcheck("R5 date 0", A_DATE, 8'h15);
      bwrite(A_YR, 8'h9A);   bcheck("R5 year bad digit", A_YR, 8'h42);
      bwrite(A_WD, 8'h00);   bcheck("R5 weekday 0", A_WD, 8'h01);
   endtask

   task automatic t_weekday();
      bwrite(A_WD, 8'h45); bcheck("R6 century and weekday", A_WD, 8'h45);
      bwrite(A_WD, 8'hFF); bcheck("R6 only bit6 kept", A_WD, 8'h47);
      bwrite(A_WD, 8'h03); bcheck("R6 century cleared", A_WD, 8'h03);
   endtask

   task automatic t_ctrl();
      bwrite(A_CTRL, 8'h00); bcheck("R7 ctrl forced ones", A_CTRL, 8'h90);
      bwrite(A_CTRL, 8'hFF); bcheck("R7 ctrl bit5 cleared", A_CTRL, 8'hDF);
      bwrite(13'h1FF0, 8'h55); bcheck("R7 flags read-only", 13'h1FF0, 8'h00);
      bcheck("R7 gap reads FF", 13'h1FF3, 8'hFF);
   endtask

   task automatic t_lock();
      bwrite(13'h0025, 8'h11); bwrite(13'h0035, 8'h22); bwrite(13'h0045, 8'h33);
      toggle(2'b01);
      bcheck("R8 window0 hidden", 13'h0025, 8'hFF);
      bcheck("R8 window1 open", 13'h0035, 8'h22);
      bwrite(13'h0025, 8'h99);
      toggle(2'b10);
      bcheck("R8 window1 hidden", 13'h0035, 8'hFF);
      bwrite(13'h0035, 8'h88);
      toggle(2'b11);
      bcheck("R8 window0 kept", 13'h0025, 8'h11);
      bcheck("R8 window1 kept", 13'h0035, 8'h22);
      bcheck("R8 outside windows", 13'h0045, 8'h33);
   endtask

   task automatic t_hole();
      bwrite(13'h0050, 8'h12); bwrite(13'h0150, 8'h77);
      bcheck("R9 beyond RAM reads FF", 13'h0150, 8'hFF);
      bcheck("R9 no alias", 13'h0050, 8'h12);
      bcheck("R9 high hole", 13'h1000, 8'hFF);
   endtask

   task automatic t_index();
      pwrite(2'd0, 8'h05); pwrite(2'd1, 8'h00); pwrite(2'd3, 8'hA5);
      bcheck("R10 indexed store", 13'h0005, 8'hA5);
      pwrite(2'd3, 8'h3C);
      bcheck("R10 latch cleared", 13'h0000, 8'h3C);
      pwrite(2'd0, 8'hFF); pwrite(2'd1, 8'h1F);
      bwrite(A_YR, 8'h57);
      pcheck("R10 indexed read", 2'd3, 8'h57);
      pcheck("R10 sel0 read FF", 2'd0, 8'hFF);
      pcheck("R10 sel2 read FF", 2'd2, 8'hFF);
   endtask

   task automatic t_collide();
      bwrite(A_SEC, 8'h10);
      bwrite_tick(A_SEC, 8'h30);
      bcheck("R11 write wins", A_SEC, 8'h30);
      bwrite(A_SEC, 8'h20);
      bwrite_tick(A_MIN, 8'h05);
      bcheck("R11 tick dropped", A_SEC, 8'h20);
      bcheck("R11 other write applied", A_MIN, 8'h05);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_advance();
      t_calendar();
      t_stop();
      t_range();
      t_weekday();
      t_ctrl();
      t_lock();
      t_hole();
      t_index();
      t_collide();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule